// File: doc/BRIEF.md
# Bus Strobe Timing Generator

This block produces the two timing strobes that an 8-bit controller drives onto its external memory bus. These are an active-high address-latch strobe and an active-low program-fetch read strobe. It divides the oscillator clock into machine cycles of twelve oscillator periods. A two-phase divider feeds a six-state sequencer. Each strobe is raised in fixed state slots.

The surrounding core supplies four inputs. Two are requests, sampled when a machine cycle begins, that mark the cycle as an external data-memory access or as a table read. The other two are level controls: one says whether code is fetched from external memory, the other holds the latch-strobe disable bit. The block also qualifies the raw reset pin. The internal core reset is raised only after the pin has been sampled high for two full machine cycles. It is released as soon as the pin is seen low.

Top module: `bus_strobe_gen`

## Requirements
- R1: With latch-disable clear and no data access, `aleOut` is high for two oscillator periods in state 1 and again in state 4 of every twelve-period machine cycle. That is one pulse per six periods. Each output lags its slot by one register.
- R2: In a machine cycle flagged as a data access, the state-4 latch pulse is dropped and the state-1 pulse remains.
- R3: `extDataReq` and `tableReadReq` are sampled only on the clock edge that starts a machine cycle. The sampled value governs that entire cycle, and a request raised and dropped in the middle of a cycle has no effect.
- R4: With `aleDisable`=1 and `extExec`=0, `aleOut` pulses only in cycles flagged as data access or table read, and stays at constant 1 in every other cycle.
- R5: With `extExec`=1, `aleDisable` has no effect on `aleOut`.
- R6: With `extExec`=1 and no data access, `psenN` is low during states 1–2 and states 4–5, giving two activations per machine cycle.
- R7: In a cycle flagged as a data access, both `psenN` activations are skipped.
- R8: With `extExec`=0, `psenN` stays high.
- R9: `coreReset` rises on the 24th consecutive clock edge on which `resetPin` is sampled high.
- R10: A low sample of `resetPin` clears `coreReset` on that edge and restarts the count. Otherwise `coreReset` stays high for as long as the pin stays high.
- R11: While `rstN` is low, `aleOut`=0, `psenN`=1 and `coreReset`=0, and the sequencer restarts at state 1, phase 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| resetPin | input | 1 | Raw external reset pin, active high |
| extDataReq | input | 1 | Next machine cycle is an external data access |
| tableReadReq | input | 1 | Next machine cycle is a table read |
| extExec | input | 1 | Code is fetched from external memory |
| aleDisable | input | 1 | Latch-strobe disable control bit |
| aleOut | output | 1 | Address-latch strobe, active high |
| psenN | output | 1 | Program-fetch read strobe, active low |
| coreReset | output | 1 | Qualified internal reset |

## Verification
A request sample and a change of a level control can land on the same cycle-boundary edge. The disable bit and the execution source are combined at once, but the request governs only the cycle that follows that edge. The bench drives the request and `aleDisable` together during the last oscillator period of a cycle. It also drives a request that rises and falls between two boundaries. A behavioural cycle model with its own period counter judges `aleOut` and `psenN` on every clock, and it also follows reset qualification while strobe traffic continues.

// File: rtl/bus_strobe_pkg.sv
package bus_strobe_pkg;

  // Slot strobes decoded by the sequencer and consumed by the datapath.
  typedef struct packed {
    logic cycleEnd;   // last oscillator period of a machine cycle
    logic aleEarly;   // first latch slot (state 1)
    logic aleLate;    // second latch slot (state 4)
    logic psenEarly;  // first fetch window (states 1-2)
    logic psenLate;   // second fetch window (states 4-5)
  } slotT;

endpackage

// File: rtl/strobe_ctrl.sv
module strobe_ctrl
  import bus_strobe_pkg::*;
#(
  parameter int STATES = 6,
  parameter int PHASES = 2
) (
  input  logic clk,
  input  logic rstN,
  output slotT tm
);

  localparam int HALF = STATES / 2;
  localparam int SW   = $clog2(STATES);
  localparam int PW   = (PHASES > 1) ? $clog2(PHASES) : 1;

  logic [PW-1:0] phaseIdx;
  logic [SW-1:0] stateIdx;
  logic          lastPhase;

  assign lastPhase = (phaseIdx == PW'(PHASES - 1));

  // Divide-by-phase stage followed by the state sequencer.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseIdx <= '0;
      stateIdx <= '0;
    end else if (lastPhase) begin
      phaseIdx <= '0;
      stateIdx <= (stateIdx == SW'(STATES - 1)) ? '0 : stateIdx + 1'b1;
    end else begin
      phaseIdx <= phaseIdx + 1'b1;
    end
  end

  always_comb begin
    tm.cycleEnd  = lastPhase && (stateIdx == SW'(STATES - 1));
    tm.aleEarly  = (stateIdx == '0);
    tm.aleLate   = (stateIdx == SW'(HALF));
    tm.psenEarly = (stateIdx < SW'(HALF - 1));
    tm.psenLate  = (stateIdx >= SW'(HALF)) && (stateIdx < SW'(STATES - 1));
  end

  // R1
  state_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    tm.cycleEnd |=> (stateIdx == '0 && phaseIdx == '0));

  // R1
  slot_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(tm.aleEarly && tm.aleLate));

endmodule

// File: rtl/strobe_dp.sv
module strobe_dp
  import bus_strobe_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  slotT tm,
  input  logic extDataReq,
  input  logic tableReadReq,
  input  logic extExec,
  input  logic aleDisable,
  output logic aleOut,
  output logic psenN
);

  logic dataFlag;
  logic tableFlag;
  logic pulse;
  logic gated;
  logic aleNext;
  logic psenNext;

  always_comb begin
    pulse    = tm.aleEarly | (tm.aleLate & ~dataFlag);
    gated    = aleDisable & ~extExec;
    aleNext  = (gated && !(dataFlag || tableFlag)) ? 1'b1 : pulse;
    psenNext = ~(extExec & ~dataFlag & (tm.psenEarly | tm.psenLate));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataFlag  <= 1'b0;
      tableFlag <= 1'b0;
      aleOut    <= 1'b0;
      psenN     <= 1'b1;
    end else begin
      if (tm.cycleEnd) begin
        dataFlag  <= extDataReq;
        tableFlag <= tableReadReq;
      end
      aleOut <= aleNext;
      psenN  <= psenNext;
    end
  end

  // R7
  psen_skip_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataFlag |=> psenN);

  // R8
  psen_internal_chk: assert property (@(posedge clk) disable iff (!rstN)
    !extExec |=> psenN);

  // R2
  ale_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataFlag && tm.aleLate) |=> !aleOut);

  // R3
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(tm.cycleEnd) |-> $stable(dataFlag));

endmodule

// File: rtl/reset_qual.sv
module reset_qual #(
  parameter int QUAL_LEN = 24
) (
  input  logic clk,
  input  logic rstN,
  input  logic resetPin,
  output logic coreReset
);

  localparam int CW = $clog2(QUAL_LEN + 1);

  logic [CW-1:0] hiCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiCnt     <= '0;
      coreReset <= 1'b0;
    end else if (!resetPin) begin
      hiCnt     <= '0;
      coreReset <= 1'b0;
    end else if (hiCnt == CW'(QUAL_LEN - 1)) begin
      coreReset <= 1'b1;
    end else begin
      hiCnt <= hiCnt + 1'b1;
    end
  end

  // R10
  rst_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !resetPin |=> !coreReset);

  // R9
  rst_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(coreReset) |-> $past(resetPin));

endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen
  import bus_strobe_pkg::*;
#(
  parameter int STATES      = 6,
  parameter int PHASES      = 2,
  parameter int QUAL_CYCLES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic resetPin,
  input  logic extDataReq,
  input  logic tableReadReq,
  input  logic extExec,
  input  logic aleDisable,
  output logic aleOut,
  output logic psenN,
  output logic coreReset
);

  localparam int OSC_PER_CYCLE = STATES * PHASES;
  localparam int QUAL_LEN      = QUAL_CYCLES * OSC_PER_CYCLE;

  slotT tm;

  strobe_ctrl #(.STATES(STATES), .PHASES(PHASES)) u_ctrl (
    .clk (clk),
    .rstN(rstN),
    .tm  (tm)
  );

  strobe_dp u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .tm          (tm),
    .extDataReq  (extDataReq),
    .tableReadReq(tableReadReq),
    .extExec     (extExec),
    .aleDisable  (aleDisable),
    .aleOut      (aleOut),
    .psenN       (psenN)
  );

  reset_qual #(.QUAL_LEN(QUAL_LEN)) u_rq (
    .clk      (clk),
    .rstN     (rstN),
    .resetPin (resetPin),
    .coreReset(coreReset)
  );

endmodule

// File: tb/test_bus_strobe_gen.sv
module test_bus_strobe_gen;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic resetPin = 1'b0;
  logic extDataReq = 1'b0;
  logic tableReadReq = 1'b0;
  logic extExec = 1'b0;
  logic aleDisable = 1'b0;
  logic aleOut, psenN, coreReset;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  string aleTag = "R11";
  string psenTag = "R11";

  // Behavioural model state.
  int k = 0;
  bit dF = 0, tF = 0;
  int hi = 0;
  bit eAle = 0, ePsen = 1, eRst = 0;

  bus_strobe_gen i_bus_strobe_gen (
    .clk(clk), .rstN(rstN), .resetPin(resetPin),
    .extDataReq(extDataReq), .tableReadReq(tableReadReq),
    .extExec(extExec), .aleDisable(aleDisable),
    .aleOut(aleOut), .psenN(psenN), .coreReset(coreReset)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (!rstN) begin
      k = 0; dF = 0; tF = 0; hi = 0;
      eAle = 0; ePsen = 1; eRst = 0;
    end else begin
      int st;
      bit inFetch;
      st = k / 2;
      inFetch = (st == 0) || (st == 1) || (st == 3) || (st == 4);
      if (aleDisable && !extExec && !dF && !tF) eAle = 1;
      else eAle = (st == 0) || (st == 3 && !dF);
      ePsen = !(extExec && !dF && inFetch);
      if (resetPin) begin
        if (hi < 24) hi++;
        eRst = (hi >= 24);
      end else begin
        hi = 0;
        eRst = 0;
      end
      if (k == 11) begin dF = extDataReq; tF = tableReadReq; end
      k = (k + 1) % 12;
    end
  end

  task automatic check1(string tag, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at %0t: actual=%b expected=%b", tag, what, $time, act, exp);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check1(aleTag, aleOut, eAle, "aleOut");
      check1(psenTag, psenN, ePsen, "psenN");
      check1("R9/R10", coreReset, eRst, "coreReset");
    end
  endtask

  // Advance until the next posedge is the cycle-boundary sample.
  task automatic toBoundary();
    step(1);
    while (k != 11) step(1);
  endtask

  initial begin
    // R11: reset state
    step(4);
    rstN = 1'b1;

    // R1 / R8: internal execution, plain pulses
    aleTag = "R1"; psenTag = "R8";
    step(40);

    // R6: external execution fetch windows
    psenTag = "R6";
    extExec = 1'b1;
    step(36);

    // R2 / R7 / R3: data request sampled at boundary, dropped right after
    aleTag = "R2/R3"; psenTag = "R7";
    toBoundary();
    extDataReq = 1'b1;
    step(1);
    extDataReq = 1'b0;
    step(26);

    // R3: request raised and dropped mid-cycle is ignored
    aleTag = "R3"; psenTag = "R3";
    while (k != 4) step(1);
    extDataReq = 1'b1;
    step(4);
    extDataReq = 1'b0;
    step(20);

    // R4: disable bit under internal execution, with table read and data cycles
    aleTag = "R4"; psenTag = "R8";
    extExec = 1'b0;
    toBoundary();
    aleDisable = 1'b1;
    tableReadReq = 1'b1;
    step(1);
    tableReadReq = 1'b0;
    step(24);
    toBoundary();
    extDataReq = 1'b1;
    step(1);
    extDataReq = 1'b0;
    step(24);

    // Boundary clash: request and disable change on the same edge
    toBoundary();
    aleDisable = 1'b0;
    extDataReq = 1'b1;
    step(1);
    extDataReq = 1'b0;
    aleDisable = 1'b1;
    step(24);

    // R5: disable bit ignored under external execution
    aleTag = "R5"; psenTag = "R6";
    extExec = 1'b1;
    step(36);

    // R9 / R10: short pulse, restart, full qualification, release
    resetPin = 1'b1; step(10);
    resetPin = 1'b0; step(3);
    resetPin = 1'b1; step(23);
    check1("R9", coreReset, 1'b0, "coreReset before 24th sample");
    step(1);
    check1("R9", coreReset, 1'b1, "coreReset after 24th sample");
    step(15);
    check1("R10", coreReset, 1'b1, "coreReset held");
    resetPin = 1'b0; step(1);
    check1("R10", coreReset, 1'b0, "coreReset released");
    step(12);

    // R11: asynchronous reset again
    rstN = 1'b0;
    #1;
    aleTag = "R11"; psenTag = "R11";
    check1("R11", aleOut, 1'b0, "aleOut in reset");
    check1("R11", psenN, 1'b1, "psenN in reset");
    check1("R11", coreReset, 1'b0, "coreReset in reset");
    step(3);
    rstN = 1'b1;
    aleTag = "R1/R11"; psenTag = "R6/R11";
    step(24);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule